// File: doc/BRIEF.md
# CPU Clock Divider and Power-Down Controller

This block sits between the main oscillator and the processor core. It turns the oscillator clock into a one-cycle CPU clock enable at one of three division ratios: divide by 4, 8 or 64. It also tracks two low-power modes. In idle, the CPU clock enable is gated off while the peripheral clock keeps running. In stop, the oscillator itself is switched off.

An interrupt request, or a reset, brings the block out of stop. After that the oscillator has to settle, so the CPU stays held for a fixed count of 2^WAIT_BITS oscillator periods before it runs again.

Software selects the division ratio by writing a small control register. It enters the low-power modes through one-cycle idle and stop command strobes. Interrupt requests arrive already masked, and any one of them wakes the block. Reset puts the block in the running state at the slowest ratio.

Top module: `pdc_clkpwr_ctrl`

## Requirements
- R1: After reset the block is running with division ratio 64. The outputs are then per_clk_en_o=1, osc_en_o=1 and cpu_hold_o=0, and the first CPU enable pulse comes 64 cycles after reset is released.
- R2: While running, cpu_clk_en_o is a single-cycle pulse once every N cycles. N is set by control bits [1:0]: 2'b11 gives 4, 2'b10 gives 8, and 2'b01 or 2'b00 give 64. The upper control bits have no effect.
- R3: A control write restarts the divider. The first pulse at the new ratio N appears on the N-th cycle after the write edge.
- R4: In idle, cpu_clk_en_o stays 0 while per_clk_en_o=1, osc_en_o=1 and cpu_hold_o=0. Idle and stop strobes received in idle have no effect.
- R5: Any interrupt request in idle returns the block to running with no stabilisation wait. The next CPU pulse comes N cycles later.
- R6: In stop, osc_en_o=0, per_clk_en_o=0, cpu_hold_o=1 and cpu_clk_en_o=0. Command strobes are ignored and the block stays in stop until an interrupt request arrives.
- R7: An interrupt in stop starts the wait. During the wait, osc_en_o=1, per_clk_en_o=1, cpu_hold_o=1 and cpu_clk_en_o=0 for exactly 2^WAIT_BITS cycles, after which the block runs. Interrupts and strobes received during the wait neither shorten it nor redirect it.
- R8: Reset from any mode, including stop, returns the block to the R1 state and ratio.
- R9: When idle and stop strobes arrive together while running, stop wins.
- R10: A command strobe that arrives in the same cycle as an interrupt request is refused. The block keeps running and CPU pulses continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | CTL_W | Control write data; bits [1:0] pick the ratio |
| idle_req_i | input | 1 | Enter-idle command strobe |
| stop_req_i | input | 1 | Enter-stop command strobe |
| irq_i | input | NIRQ | Masked interrupt requests, any one wakes |
| cpu_clk_en_o | output | 1 | CPU clock enable pulse |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_hold_o | output | 1 | CPU held during stop and stabilisation |

## Verification
On every cycle the assertions check the following:
- the set of outputs in stop;
- that no CPU pulse occurs while the CPU is held;
- that CPU pulses are never longer than one cycle;
- that the oscillator restarts only with the CPU held;
- that every stabilisation wait lasts exactly 2^WAIT_BITS cycles.

Only the directed scenarios can show the rest:
- that each ratio encoding produces the right period;
- that a write restarts the divider;
- that strobes in idle or during the wait are ignored;
- that stop takes priority over idle;
- that commands are refused while an interrupt is pending;
- that reset from stop brings back the slow ratio.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_IDLE = 2'd1,
      PM_STOP = 2'd2,
      PM_WAIT = 2'd3
   } pm_state_e;

   localparam logic [1:0] SEL_FAST = 2'b11;
   localparam logic [1:0] SEL_MID  = 2'b10;
endpackage

// File: rtl/pdc_clkdiv.sv
module pdc_clkdiv #(
   parameter int DIV_FAST = 4,
   parameter int DIV_MID  = 8,
   parameter int DIV_SLOW = 64
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       run_i,
   input  logic       restart_i,
   input  logic [1:0] sel_i,
   output logic       tick_o
);
   import pdc_pkg::*;

   localparam int CW = $clog2(DIV_SLOW);
   localparam int LW = CW + 1;

   if (DIV_FAST < 2 || DIV_MID < DIV_FAST || DIV_SLOW < DIV_MID) begin : g_bad_ratio
      $error("pdc_clkdiv: ratios must satisfy 2 <= FAST <= MID <= SLOW");
   end

   logic [LW-1:0] lim;
   logic [CW-1:0] cnt_q;
   logic          at_end;

   always_comb begin
      case (sel_i)
         SEL_FAST: lim = LW'(DIV_FAST);
         SEL_MID:  lim = LW'(DIV_MID);
         default:  lim = LW'(DIV_SLOW);
      endcase
   end

   assign at_end = ({1'b0, cnt_q} == (lim - LW'(1)));
   assign tick_o = run_i && at_end;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!run_i || restart_i || at_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/pdc_waitcnt.sv
module pdc_waitcnt #(
   parameter int WAIT_BITS = 17
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic done_o
);
   if (WAIT_BITS < 1) begin : g_bad_wait
      $error("pdc_waitcnt: WAIT_BITS must be at least 1");
   end

   logic [WAIT_BITS-1:0] cnt_q;

   assign done_o = en_i && (&cnt_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!en_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + WAIT_BITS'(1);
      end
   end
endmodule

// File: rtl/pdc_pmfsm.sv
module pdc_pmfsm (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                idle_req_i,
   input  logic                stop_req_i,
   input  logic                wake_i,
   input  logic                wait_done_i,
   output pdc_pkg::pm_state_e  state_o
);
   import pdc_pkg::*;

   pm_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         PM_RUN: begin
            if (!wake_i) begin
               if (stop_req_i)      state_d = PM_STOP;
               else if (idle_req_i) state_d = PM_IDLE;
            end
         end
         PM_IDLE: if (wake_i)      state_d = PM_RUN;
         PM_STOP: if (wake_i)      state_d = PM_WAIT;
         PM_WAIT: if (wait_done_i) state_d = PM_RUN;
         default: state_d = PM_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= PM_RUN;
      else         state_q <= state_d;
   end

   assign state_o = state_q;
endmodule

// File: rtl/pdc_clkpwr_ctrl.sv
module pdc_clkpwr_ctrl #(
   parameter int DIV_FAST  = 4,
   parameter int DIV_MID   = 8,
   parameter int DIV_SLOW  = 64,
   parameter int WAIT_BITS = 17,
   parameter int CTL_W     = 4,
   parameter int NIRQ      = 4,
   parameter bit WAKE_SYNC = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ctl_we_i,
   input  logic [CTL_W-1:0] ctl_wdata_i,
   input  logic             idle_req_i,
   input  logic             stop_req_i,
   input  logic [NIRQ-1:0]  irq_i,
   output logic             cpu_clk_en_o,
   output logic             per_clk_en_o,
   output logic             osc_en_o,
   output logic             cpu_hold_o
);
   import pdc_pkg::*;

   if (CTL_W < 2) begin : g_bad_ctl
      $error("pdc_clkpwr_ctrl: CTL_W must be at least 2");
   end
   if (NIRQ < 1) begin : g_bad_irq
      $error("pdc_clkpwr_ctrl: NIRQ must be at least 1");
   end

   logic [1:0] sel_q;
   logic       wake;
   logic       wait_done;
   logic       tick;
   pm_state_e  state;

   if (CTL_W > 2) begin : g_hi_bits
      logic unused_hi;
      assign unused_hi = ^ctl_wdata_i[CTL_W-1:2];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sel_q <= 2'b00;
      else if (ctl_we_i) sel_q <= ctl_wdata_i[1:0];
   end

   if (WAKE_SYNC) begin : g_wake_reg
      logic wake_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) wake_q <= 1'b0;
         else         wake_q <= |irq_i;
      end
      assign wake = wake_q;
   end else begin : g_wake_comb
      assign wake = |irq_i;
   end

   pdc_pmfsm u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .idle_req_i  (idle_req_i),
      .stop_req_i  (stop_req_i),
      .wake_i      (wake),
      .wait_done_i (wait_done),
      .state_o     (state)
   );

   pdc_clkdiv #(
      .DIV_FAST (DIV_FAST),
      .DIV_MID  (DIV_MID),
      .DIV_SLOW (DIV_SLOW)
   ) u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (state == PM_RUN),
      .restart_i (ctl_we_i),
      .sel_i     (sel_q),
      .tick_o    (tick)
   );

   pdc_waitcnt #(
      .WAIT_BITS (WAIT_BITS)
   ) u_wait (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (state == PM_WAIT),
      .done_o (wait_done)
   );

   assign cpu_clk_en_o = tick;
   assign osc_en_o     = (state != PM_STOP);
   assign per_clk_en_o = (state != PM_STOP);
   assign cpu_hold_o   = (state == PM_STOP) || (state == PM_WAIT);
endmodule

// File: rtl/pdc_clkpwr_chk.sv
module pdc_clkpwr_chk #(
   parameter int WAIT_BITS = 17,
   parameter int CTL_W     = 4,
   parameter int NIRQ      = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             ctl_we_i,
   input logic [CTL_W-1:0] ctl_wdata_i,
   input logic             idle_req_i,
   input logic             stop_req_i,
   input logic [NIRQ-1:0]  irq_i,
   input logic             cpu_clk_en_o,
   input logic             per_clk_en_o,
   input logic             osc_en_o,
   input logic             cpu_hold_o
);
   localparam logic [WAIT_BITS:0] FULL = (WAIT_BITS+1)'(1) << WAIT_BITS;

   logic [WAIT_BITS:0] hold_cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     hold_cnt_q <= '0;
      else if (osc_en_o && cpu_hold_o) hold_cnt_q <= hold_cnt_q + (WAIT_BITS+1)'(1);
      else                             hold_cnt_q <= '0;
   end

   // R6
   stop_outputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !osc_en_o |-> (!per_clk_en_o && cpu_hold_o && !cpu_clk_en_o));

   // R2
   pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_clk_en_o |=> !cpu_clk_en_o);

   // R7
   held_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_hold_o |-> !cpu_clk_en_o);

   // R7
   restart_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(osc_en_o) |-> cpu_hold_o);

   // R7
   wait_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cpu_hold_o) |-> (hold_cnt_q == FULL));

   // R7
   wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_cnt_q <= FULL);

   logic unused_chk;
   assign unused_chk = ctl_we_i ^ (^ctl_wdata_i) ^ idle_req_i ^ stop_req_i ^ (^irq_i);
endmodule

bind pdc_clkpwr_ctrl pdc_clkpwr_chk #(
   .WAIT_BITS (WAIT_BITS),
   .CTL_W     (CTL_W),
   .NIRQ      (NIRQ)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .ctl_we_i     (ctl_we_i),
   .ctl_wdata_i  (ctl_wdata_i),
   .idle_req_i   (idle_req_i),
   .stop_req_i   (stop_req_i),
   .irq_i        (irq_i),
   .cpu_clk_en_o (cpu_clk_en_o),
   .per_clk_en_o (per_clk_en_o),
   .osc_en_o     (osc_en_o),
   .cpu_hold_o   (cpu_hold_o)
);

// File: tb/tb_pdc_clkpwr_ctrl.sv
module tb_pdc_clkpwr_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int WB   = 6;
   localparam int WLEN = 1 << WB;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [3:0] ctl_wdata = 4'h0;
   logic       idle_req = 1'b0;
   logic       stop_req = 1'b0;
   logic [3:0] irq = 4'h0;
   logic       cpu_en, per_en, osc_en, hold;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pdc_clkpwr_ctrl #(.WAIT_BITS(WB)) dut (
      .clk_i (clk), .rst_ni (rst_n), .ctl_we_i (ctl_we), .ctl_wdata_i (ctl_wdata),
      .idle_req_i (idle_req), .stop_req_i (stop_req), .irq_i (irq),
      .cpu_clk_en_o (cpu_en), .per_clk_en_o (per_en), .osc_en_o (osc_en),
      .cpu_hold_o (hold)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // outputs packed as {cpu,per,osc,hold}
   function automatic int outs();
      return {cpu_en, per_en, osc_en, hold};
   endfunction

   // current negedge counts as cycle 1; expect a pulse on cycle n only
   task automatic expect_first_tick(input string req, input int n);
      int at = 0;
      for (int i = 1; i <= n; i++) begin
         if (cpu_en && at == 0) at = i;
         if (i < n) step();
      end
      check(req, at, n);
   endtask

   task automatic period_after_tick(input string req, input int n);
      int gap = 0;
      for (int i = 1; i <= 200; i++) begin
         step();
         if (cpu_en) begin gap = i; break; end
      end
      check(req, gap, n);
   endtask

   task automatic write_ctl(input logic [3:0] v);
      ctl_wdata = v; ctl_we = 1'b1;
      step();
      ctl_we = 1'b0;
   endtask

   task automatic pulse(input bit doidle, input bit dostop, input bit dirq);
      idle_req = doidle; stop_req = dostop; irq = dirq ? 4'b0100 : 4'h0;
      step();
      idle_req = 1'b0; stop_req = 1'b0; irq = 4'h0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step(); step();
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      do_reset();
      // R1: run, slow ratio
      check("R1 outputs", outs(), 4'b0110);
      expect_first_tick("R1 first pulse", 64);
      period_after_tick("R1 period", 64);
   endtask

   task automatic t_ratios();
      write_ctl(4'b0011);
      expect_first_tick("R3 restart /4", 4);
      period_after_tick("R2 period 11", 4);
      write_ctl(4'b0010);
      expect_first_tick("R3 restart /8", 8);
      period_after_tick("R2 period 10", 8);
      write_ctl(4'b0001);
      expect_first_tick("R2 code 01", 64);
      write_ctl(4'b1100);
      expect_first_tick("R2 upper bits 1100", 64);
      write_ctl(4'b0111);
      expect_first_tick("R2 upper bits 0111", 4);
      period_after_tick("R2 period 0111", 4);
   endtask

   task automatic t_idle();
      int bad = 0;
      pulse(1'b1, 1'b0, 1'b0);
      check("R4 idle outputs", outs(), 4'b0110);
      pulse(1'b0, 1'b1, 1'b0);
      pulse(1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 20; i++) begin
         if (outs() != 4'b0110) bad++;
         step();
      end
      check("R4 idle strobes ignored", bad, 0);
      pulse(1'b0, 1'b0, 1'b1);
      expect_first_tick("R5 idle wake", 4);
   endtask

   task automatic wait_out(input string req, input bit poke);
      int len = 0;
      check({req, " wait outputs"}, outs(), 4'b0111);
      for (int i = 1; i <= 4 * WLEN; i++) begin
         if (!hold) break;
         len++;
         if (poke && i == 10) irq = 4'b0001;
         else if (poke && i == 20) idle_req = 1'b1;
         else if (poke && i == 30) stop_req = 1'b1;
         step();
         irq = 4'h0; idle_req = 1'b0; stop_req = 1'b0;
      end
      check({req, " wait length"}, len, WLEN);
   endtask

   task automatic t_stop();
      int bad = 0;
      pulse(1'b0, 1'b1, 1'b0);
      check("R6 stop outputs", outs(), 4'b0001);
      pulse(1'b1, 1'b0, 1'b0);
      pulse(1'b0, 1'b1, 1'b0);
      for (int i = 0; i < 15; i++) begin
         if (outs() != 4'b0001) bad++;
         step();
      end
      check("R6 stays stopped", bad, 0);
      pulse(1'b0, 1'b0, 1'b1);
      wait_out("R7", 1'b1);
      expect_first_tick("R7 run after wait", 4);
   endtask

   task automatic t_priority();
      pulse(1'b1, 1'b1, 1'b0);
      check("R9 stop wins", outs(), 4'b0001);
      pulse(1'b0, 1'b0, 1'b1);
      wait_out("R9", 1'b0);
   endtask

   task automatic t_pending();
      int ticks = 0;
      pulse(1'b1, 1'b0, 1'b1);
      check("R10 idle refused", {per_en, osc_en, hold}, 3'b110);
      for (int i = 0; i < 8; i++) begin
         if (cpu_en) ticks++;
         step();
      end
      check("R10 pulses continue", ticks, 2);
      pulse(1'b0, 1'b1, 1'b1);
      check("R10 stop refused", {per_en, osc_en, hold}, 3'b110);
   endtask

   task automatic t_reset_from_stop();
      pulse(1'b0, 1'b1, 1'b0);
      check("R8 in stop", outs(), 4'b0001);
      do_reset();
      check("R8 outputs", outs(), 4'b0110);
      expect_first_tick("R8 ratio back to 64", 64);
   endtask

   initial begin
      step();
      t_reset_state();
      t_ratios();
      t_idle();
      t_stop();
      t_priority();
      t_pending();
      t_reset_from_stop();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule